// File: doc/BRIEF.md
# Raised-Cosine Soft Mute Ramp

This block sits in a stereo PCM sample path. It scales every sample pair by a shared gain, so muting and unmuting fade along a raised-cosine curve instead of switching abruptly. Each new sample pair arrives with a one-cycle strobe. The scaled pair leaves one clock later with its own strobe.

The gain moves through a table of cosine values. A step index selects the entry, and the index moves by one after every 32 strobed samples. A full fade from unity gain to silence therefore spans 1024 samples, and the way back spans another 1024 samples through the same values in reverse. A mode input picks where the mute request comes from. In pin mode it comes from a static pin. In register mode it comes from a control-register bit, the block leaves reset fully muted, and the pin is ignored. A status output reports when the gain has reached the level that the current request asks for.

Top module: `soft_mute_ramp`

## Requirements
- R1: With gain fraction bits GF=16, the gain at step k (k = 0..31) is round(65536 · (1 + cos(π·k/32)) / 2), where round means floor(x + 0.5). Step 32 has gain 0.
- R2: While mute is requested, the step index rises by one after each 32 strobed samples and stops at 32. A fade from step 0 to step 32 takes exactly 1024 strobes.
- R3: While unmute is requested, the step index falls by one after each 32 strobed samples and stops at 0. A fade from step 32 to step 0 takes exactly 1024 strobes.
- R4: When the request reverses mid-ramp, the index keeps its current value, moves by at most one per strobe, and heads the other way. The count of strobes within the current step is not restarted.
- R5: At step 0, the outputs equal the inputs bit for bit. At step 32, both outputs are exactly zero.
- R6: Each output is floor((s·g + 32768) / 65536), where s is the signed 20-bit input and g is the gain of the step index held before that strobe.
- R7: Left and right use the same gain on every strobe.
- R8: With ctl_mode = 0, the request is mute_pin and mute_bit has no effect. Reset leaves step 0.
- R9: With ctl_mode = 1, the request is mute_bit and mute_pin has no effect. Reset leaves step 32, so the outputs are zero until mute_bit is cleared.
- R10: ramp_done is 1 when the index is at 32 under a mute request, or at 0 under an unmute request. Otherwise it is 0.
- R11: out_vld is 1 exactly one cycle after in_vld. Without a strobe, the index does not move and the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_mode | input | 1 | Request source: 0 = pin, 1 = register bit |
| mute_pin | input | 1 | Static mute request pin |
| mute_bit | input | 1 | Mute bit from the control register |
| in_vld | input | 1 | Sample-pair strobe |
| in_l | input | 20 | Left sample, signed |
| in_r | input | 20 | Right sample, signed |
| out_vld | output | 1 | Scaled-pair strobe |
| out_l | output | 20 | Scaled left sample |
| out_r | output | 20 | Scaled right sample |
| ramp_done | output | 1 | Gain has reached the requested end level |

## Verification
A single strobe does two things in the same edge: it scales a sample pair, and it can advance the step index. The scaled pair must use the gain from before the advance. The bench strobes without a break through every step boundary of full fades, and reverses the request at a point where the within-step count is not zero. A cycle-level model of index and count predicts every output sample and every ramp_done value, so an off-by-one in when the gain changes, or a jump at a reversal, shows up as a mismatch.

// File: rtl/smr_pkg.sv
`timescale 1ns/1ps
package smr_pkg;
  // Elaboration-time cosine gain: round(2^gf * (1 + cos(pi*k/steps)) / 2)
  function automatic int smr_cos_gain(input int k, input int steps, input int gf);
    real x, x2, term, c;
    x    = 3.14159265358979323846 * k / steps;
    x2   = x * x;
    term = 1.0;
    c    = 1.0;
    for (int n = 1; n < 24; n++) begin
      term = -term * x2 / ((2.0 * n - 1.0) * (2.0 * n));
      c    = c + term;
    end
    return $rtoi((2.0 ** gf) * (1.0 + c) / 2.0 + 0.5);
  endfunction
endpackage

// File: rtl/smr_gain_rom.sv
`timescale 1ns/1ps
module smr_gain_rom #(
  parameter int STEPS = 32,
  parameter int GF    = 16,
  parameter int IW    = 6
) (
  input  logic [IW-1:0] idx,
  output logic [GF:0]   gain
);
  localparam int DEPTH = 2 ** IW;

  logic [GF:0] tab [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_tab
    if (k < STEPS) begin : g_cos
      localparam int GV = smr_pkg::smr_cos_gain(k, STEPS, GF);
      assign tab[k] = GV[GF:0];
    end else begin : g_zero
      assign tab[k] = '0;
    end
  end

  assign gain = tab[idx];
endmodule

// File: rtl/smr_ramp_ctrl.sv
`timescale 1ns/1ps
module smr_ramp_ctrl #(
  parameter int STEPS = 32,
  parameter int HOLD  = 32,
  parameter int IW    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_muted,
  input  logic          step,
  input  logic          req,
  output logic [IW-1:0] idx
);
  localparam int            CW      = $clog2(HOLD);
  localparam logic [IW-1:0] TOP_IDX = IW'(STEPS);
  localparam logic [CW-1:0] LAST    = CW'(HOLD - 1);

  logic [CW-1:0] cnt;
  logic          moving;

  assign moving = req ? (idx != TOP_IDX) : (idx != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= start_muted ? TOP_IDX : '0;
      cnt <= '0;
    end else if (step && moving) begin
      if (cnt == LAST) begin
        cnt <= '0;
        idx <= req ? idx + 1'b1 : idx - 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2 R3: index stays within the table plus the silent step
  a_r2_idx_range: assert property (@(posedge clk) disable iff (rst)
    idx <= TOP_IDX);

  // R4: the gain never skips a step
  a_r4_no_jump: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (idx == $past(idx)) || (idx == $past(idx) + 1'b1) || (idx + 1'b1 == $past(idx)));

  // R2: under a mute request the index never goes down
  a_r2_mute_direction: assert property (@(posedge clk) disable iff (rst)
    req |=> idx >= $past(idx));

  // R11: no strobe, no movement
  a_r11_hold_no_strobe: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(idx));
endmodule

// File: rtl/smr_scale.sv
`timescale 1ns/1ps
module smr_scale #(
  parameter int DW = 20,
  parameter int GF = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [GF:0]          gain,
  input  logic signed [DW-1:0] smp,
  output logic signed [DW-1:0] res
);
  localparam int PW = DW + GF + 2;
  localparam logic signed [PW-1:0] HALF = {{(PW-GF){1'b0}}, 1'b1, {(GF-1){1'b0}}};

  logic signed [PW-1:0] a_ext, g_ext, rounded;

  assign a_ext   = PW'(smp);
  assign g_ext   = PW'($signed({1'b0, gain}));
  assign rounded = a_ext * g_ext + HALF;

  always_ff @(posedge clk) begin
    if (rst)     res <= '0;
    else if (en) res <= DW'(rounded >>> GF);
  end
endmodule

// File: rtl/soft_mute_ramp.sv
`timescale 1ns/1ps
module soft_mute_ramp #(
  parameter int DW    = 20,
  parameter int GF    = 16,
  parameter int STEPS = 32,
  parameter int HOLD  = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctl_mode,
  input  logic                 mute_pin,
  input  logic                 mute_bit,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_l,
  input  logic signed [DW-1:0] in_r,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_l,
  output logic signed [DW-1:0] out_r,
  output logic                 ramp_done
);
  localparam int            IW      = $clog2(STEPS + 1);
  localparam int            NCH     = 2;
  localparam logic [IW-1:0] TOP_IDX = IW'(STEPS);

  logic          req_q;
  logic [IW-1:0] idx;
  logic [GF:0]   gain;
  logic signed [DW-1:0] ch_in  [NCH];
  logic signed [DW-1:0] ch_out [NCH];

  // Request source: register bit in register mode, pin otherwise
  always_ff @(posedge clk) begin
    if (rst) req_q <= ctl_mode;
    else     req_q <= ctl_mode ? mute_bit : mute_pin;
  end

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= in_vld;
  end

  smr_ramp_ctrl #(.STEPS(STEPS), .HOLD(HOLD), .IW(IW)) u_ctrl (
    .clk(clk), .rst(rst), .start_muted(ctl_mode),
    .step(in_vld), .req(req_q), .idx(idx)
  );

  smr_gain_rom #(.STEPS(STEPS), .GF(GF), .IW(IW)) u_rom (
    .idx(idx), .gain(gain)
  );

  assign ch_in[0] = in_l;
  assign ch_in[1] = in_r;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    smr_scale #(.DW(DW), .GF(GF)) u_scale (
      .clk(clk), .rst(rst), .en(in_vld), .gain(gain),
      .smp(ch_in[c]), .res(ch_out[c])
    );
  end

  assign out_l     = ch_out[0];
  assign out_r     = ch_out[1];
  assign ramp_done = req_q ? (idx == TOP_IDX) : (idx == '0);

  // R5: silent step gives exact zero
  a_r5_zero_gain: assert property (@(posedge clk) disable iff (rst)
    (out_vld && $past(idx) == TOP_IDX) |-> (out_l == '0 && out_r == '0));

  // R5: unity step is bit-exact
  a_r5_unity_pass: assert property (@(posedge clk) disable iff (rst)
    (out_vld && $past(idx) == '0) |-> (out_l == $past(in_l) && out_r == $past(in_r)));

  // R7: equal inputs give equal outputs
  a_r7_same_gain: assert property (@(posedge clk) disable iff (rst)
    (out_vld && $past(in_l) == $past(in_r)) |-> out_l == out_r);

  // R11: output strobe follows input strobe by one cycle
  a_r11_strobe_latency: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);
endmodule

// File: tb/soft_mute_ramp_test.sv
`timescale 1ns/1ps
module soft_mute_ramp_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_mode = 1'b0, mute_pin = 1'b0, mute_bit = 1'b0, in_vld = 1'b0;
  logic signed [19:0] in_l = '0, in_r = '0;
  logic out_vld, ramp_done;
  logic signed [19:0] out_l, out_r;

  int checks = 0, errors = 0;
  int midx = 0, mcnt = 0, mreq = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  soft_mute_ramp uut (
    .clk(clk), .rst(rst), .ctl_mode(ctl_mode), .mute_pin(mute_pin),
    .mute_bit(mute_bit), .in_vld(in_vld), .in_l(in_l), .in_r(in_r),
    .out_vld(out_vld), .out_l(out_l), .out_r(out_r), .ramp_done(ramp_done)
  );

  // stimulus and expected result at unity gain: {left, right, exp_left, exp_right}
  localparam logic signed [19:0] VEC [8][4] = '{
    '{20'sd0,       20'sd0,       20'sd0,       20'sd0},
    '{20'sd1,       -20'sd1,      20'sd1,       -20'sd1},
    '{20'sd524287,  -20'sd524288, 20'sd524287,  -20'sd524288},
    '{-20'sd524288, 20'sd524287,  -20'sd524288, 20'sd524287},
    '{20'sd12345,   20'sd54321,   20'sd12345,   20'sd54321},
    '{-20'sd77777,  20'sd3,       -20'sd77777,  20'sd3},
    '{20'sd262144,  -20'sd131072, 20'sd262144,  -20'sd131072},
    '{-20'sd5,      20'sd99999,   -20'sd5,      20'sd99999}
  };

  function automatic longint gain_of(input int k);
    if (k >= 32) return 0;
    return longint'($floor(65536.0 * (1.0 + $cos(3.14159265358979323846 * k / 32.0)) / 2.0 + 0.5));
  endfunction

  function automatic longint scaled(input longint s, input longint g);
    longint p;
    p = s * g + 32768;
    return p >>> 16;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    if ((mreq != 0 && midx < 32) || (mreq == 0 && midx > 0)) begin
      if (mcnt == 31) begin
        mcnt = 0;
        midx = (mreq != 0) ? midx + 1 : midx - 1;
      end else mcnt++;
    end
  endtask

  task automatic strobe(input logic signed [19:0] l, input logic signed [19:0] r,
                        input string tag);
    longint g, el, er;
    @(negedge clk);
    in_vld = 1'b1; in_l = l; in_r = r;
    g  = gain_of(midx);
    el = scaled(longint'(l), g);
    er = scaled(longint'(r), g);
    model_step();
    @(negedge clk);
    in_vld = 1'b0;
    chk(tag, "out_vld", longint'(out_vld), 1);
    chk(tag, "out_l", longint'(out_l), el);
    chk(tag, "out_r", longint'(out_r), er);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++)
      strobe(20'(i * 40503 + 12345), 20'(i * 91141 - 7777), tag);
  endtask

  task automatic chk_done(input string tag);
    longint exp;
    exp = ((mreq != 0 && midx == 32) || (mreq == 0 && midx == 0)) ? 1 : 0;
    chk(tag, "ramp_done", longint'(ramp_done), exp);
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst = 1'b1; ctl_mode = mode;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    midx = (mode) ? 32 : 0; mcnt = 0;
    mreq = (mode) ? 1 : 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R11 watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // Reset state in pin mode (R8 R10)
    mute_pin = 1'b0; mute_bit = 1'b0;
    do_reset(1'b0);
    chk("R11", "out_vld after reset", longint'(out_vld), 0);
    chk("R8", "out_l after reset", longint'(out_l), 0);
    chk("R10", "ramp_done after reset", longint'(ramp_done), 1);

    // Unity gain vectors (R5 R7)
    for (int i = 0; i < 8; i++) begin
      strobe(VEC[i][0], VEC[i][1], "R5 R7");
      chk("R5", "unity left", longint'(out_l), longint'(VEC[i][2]));
      chk("R5", "unity right", longint'(out_r), longint'(VEC[i][3]));
    end

    // Register bit ignored in pin mode (R8)
    mute_bit = 1'b1;
    run(40, "R8");
    chk("R8", "unity held with bit set", longint'(midx), 0);
    chk_done("R8");
    mute_bit = 1'b0;

    // Full mute fade: each sample checked against the cosine gain (R1 R2 R6)
    mute_pin = 1'b1; mreq = 1;
    run(1023, "R1 R2 R6");
    chk("R2", "ramp_done before last strobe", longint'(ramp_done), 0);
    run(1, "R2");
    chk("R2", "ramp_done after 1024 strobes", longint'(ramp_done), 1);
    for (int i = 0; i < 8; i++) begin
      strobe(VEC[i][0], VEC[i][1], "R5");
      chk("R5", "silent left", longint'(out_l), 0);
    end

    // No strobe, nothing moves (R11)
    repeat (5) begin
      @(negedge clk);
      chk("R11", "out_vld idle", longint'(out_vld), 0);
    end

    // Unmute part way, reverse, reverse again (R3 R4 R10)
    mute_pin = 1'b0; mreq = 0;
    run(500, "R3");
    chk_done("R10");
    mute_pin = 1'b1; mreq = 1;
    run(100, "R4");
    chk_done("R4");
    mute_pin = 1'b0; mreq = 0;
    while (midx != 0 || mcnt != 0) run(1, "R3 R4");
    chk("R3", "ramp_done back at unity", longint'(ramp_done), 1);
    strobe(20'sd4242, -20'sd4242, "R5");
    chk("R5", "unity after unmute", longint'(out_l), 4242);

    // Register mode: starts muted, pin ignored (R9)
    mute_bit = 1'b1; mute_pin = 1'b0;
    do_reset(1'b1);
    chk("R9", "ramp_done muted at reset", longint'(ramp_done), 1);
    run(40, "R9");
    chk("R9", "still silent with pin low", longint'(out_l), 0);
    mute_pin = 1'b1;
    run(4, "R9");
    mute_pin = 1'b0;
    run(4, "R9");
    chk("R9", "pin toggles ignored", longint'(midx), 32);
    chk_done("R9");

    // Clearing the bit unmutes over 1024 strobes (R9 R3)
    mute_bit = 1'b0; mreq = 0;
    run(1023, "R9 R3");
    chk("R3", "ramp_done before end of unmute", longint'(ramp_done), 0);
    run(1, "R3");
    chk("R3", "ramp_done after unmute", longint'(ramp_done), 1);
    strobe(-20'sd300000, 20'sd300000, "R5");
    chk("R5", "unity in register mode", longint'(out_l), -300000);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule